// File: doc/BRIEF.md
# Dispatch Group Admission Gate

This block sits beside an in-order dispatch stage that bundles decoded instructions into groups of up to five slots. Each cycle it looks at the descriptor of the next instruction (its execution-unit class and a handful of flags) and raises a hazard when that instruction cannot legally join the group currently being built. Examples are an instruction that must lead a group, a two-slot instruction that no longer fits, a non-branch trying to take the branch-only last slot, or a branch through the count register after the count register was written earlier in the same group.

The dispatcher completes a handshake by asserting accept alongside valid. On a handshake with no hazard the instruction is admitted and the slot count advances. A handshake while the hazard is raised closes the group, and the instruction is left to be offered again. Admitting a branch or a single instruction also closes the group. One cycle after any close, a group-start pulse marks the fresh, empty group.

Top module: `dgrp_slot_gate`

## Requirements
- R1: After reset the group is empty with no count-register write recorded, grp_start_o is low, and a first-only instruction is admitted without hazard.
- R2: An instruction with first_only_i or single_i set raises a hazard whenever at least one slot of the current group is occupied.
- R3: An instruction with cracked_i set takes two slots when admitted, and raises a hazard when more than two slots are already occupied.
- R4: Unit codes 0 to 4 (fixed-point, load/store, floating-point, vector ALU, vector permute) and the spare code 7 raise a hazard when four slots are occupied, so only unit code 6 (branch) can take the fifth slot.
- R5: Unit code 5 (condition-register logic) raises a hazard when two or more slots are occupied.
- R6: An instruction with uses_ctr_i set raises a hazard when an instruction with sets_ctr_i set was admitted earlier in the same group.
- R7: An instruction with pseudo_i set never raises a hazard and changes neither the slot count, nor the count-register record, nor grp_start_o, whatever its other fields hold.
- R8: Admitting a unit-code-6 instruction or an instruction with single_i set closes the group.
- R9: A handshake while hazard_o is high closes the group without admitting the instruction.
- R10: In the cycle after a close, grp_start_o is high for exactly one cycle, the slot count is zero and the count-register record is cleared.
- R11: hazard_o is low while in_valid_i is low, and without a valid-and-accept handshake the group state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | A descriptor is present |
| in_accept_i | input | 1 | Dispatcher takes this cycle's decision |
| unit_i | input | 3 | Execution-unit class code |
| first_only_i | input | 1 | Instruction must lead a group |
| single_i | input | 1 | Instruction must lead and fill a group |
| cracked_i | input | 1 | Instruction occupies two slots |
| pseudo_i | input | 1 | Instruction occupies no slot |
| sets_ctr_i | input | 1 | Instruction writes the count register |
| uses_ctr_i | input | 1 | Instruction branches through the count register |
| hazard_o | output | 1 | Instruction cannot join the current group |
| grp_start_o | output | 1 | One-cycle pulse: a new group begins |

## Verification
The assertions assume well-formed descriptors: no X on the inputs, a cracked instruction never of branch class, and a branch-through-count-register instruction only ever of branch class. The directed stimulus keeps to these: it builds every descriptor from a class code and a set of flags that a real decoder could emit. It closes each group with a branch or a refused handshake before the next scenario starts.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

    typedef enum logic [2:0] {
        UNIT_FIX   = 3'd0,
        UNIT_LDST  = 3'd1,
        UNIT_FLT   = 3'd2,
        UNIT_VALU  = 3'd3,
        UNIT_VPERM = 3'd4,
        UNIT_CR    = 3'd5,
        UNIT_BR    = 3'd6,
        UNIT_SPARE = 3'd7
    } unit_e;

endpackage

// File: rtl/dgrp_rules.sv
// Combinational admission rules: one hit bit per rule, ORed into a hazard.
module dgrp_rules
    import dgrp_pkg::*;
#(
    parameter int NUM_SLOTS   = 5,
    parameter int CR_LIMIT    = 2,
    parameter int CRACK_SLOTS = 2,
    parameter int CNT_W       = 3
) (
    input  logic [2:0]       unit_i,
    input  logic             first_only_i,
    input  logic             single_i,
    input  logic             cracked_i,
    input  logic             pseudo_i,
    input  logic             uses_ctr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ctr_set_i,
    output logic             hazard_o
);

    localparam int LAST_SLOT = NUM_SLOTS - 1;
    localparam int CRACK_MAX = NUM_SLOTS - 1 - CRACK_SLOTS;
    localparam int NUM_RULES = 5;

    unit_e                unit;
    logic                 is_cr;
    logic                 is_body;
    logic [NUM_RULES-1:0] hit;

    assign unit    = unit_e'(unit_i);
    assign is_cr   = (unit == UNIT_CR);
    assign is_body = (unit != UNIT_CR) && (unit != UNIT_BR);

    // leader-only instructions need an empty group
    assign hit[0] = (first_only_i || single_i) && (cnt_i != '0);

    // a multi-slot instruction must fit entirely before the branch slot
    generate
        if (CRACK_SLOTS > 1) begin : g_crack
            assign hit[1] = cracked_i && (cnt_i > CNT_W'(CRACK_MAX));
        end else begin : g_no_crack
            assign hit[1] = 1'b0;
        end
    endgenerate

    // last slot reserved for branches
    assign hit[2] = is_body && (cnt_i == CNT_W'(LAST_SLOT));

    // condition-register logic only in the leading slots
    assign hit[3] = is_cr && (cnt_i >= CNT_W'(CR_LIMIT));

    // write-then-branch through the count register in one group
    assign hit[4] = uses_ctr_i && ctr_set_i;

    assign hazard_o = !pseudo_i && (|hit);

endmodule

// File: rtl/dgrp_state.sv
// Group state: slot count, count-register record, start pulse.
module dgrp_state #(
    parameter int CRACK_SLOTS = 2,
    parameter int CNT_W       = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fire_i,
    input  logic             hazard_i,
    input  logic             is_br_i,
    input  logic             single_i,
    input  logic             cracked_i,
    input  logic             sets_ctr_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ctr_set_q,
    output logic             start_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ctr_set;
        logic             start;
    } grp_st_t;

    grp_st_t          st_d;
    grp_st_t          st_q;
    logic [CNT_W-1:0] step;
    logic             close;

    assign step  = cracked_i ? CNT_W'(CRACK_SLOTS) : CNT_W'(1);
    assign close = hazard_i || is_br_i || single_i;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (fire_i) begin
            if (close) begin
                st_d.cnt     = '0;
                st_d.ctr_set = 1'b0;
                st_d.start   = 1'b1;
            end else begin
                st_d.cnt     = st_q.cnt + step;
                st_d.ctr_set = st_q.ctr_set || sets_ctr_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q     = st_q.cnt;
    assign ctr_set_q = st_q.ctr_set;
    assign start_q   = st_q.start;

endmodule

// File: rtl/dgrp_slot_gate.sv
module dgrp_slot_gate
    import dgrp_pkg::*;
#(
    parameter int NUM_SLOTS   = 5,
    parameter int CR_LIMIT    = 2,
    parameter int CRACK_SLOTS = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       in_valid_i,
    input  logic       in_accept_i,
    input  logic [2:0] unit_i,
    input  logic       first_only_i,
    input  logic       single_i,
    input  logic       cracked_i,
    input  logic       pseudo_i,
    input  logic       sets_ctr_i,
    input  logic       uses_ctr_i,
    output logic       hazard_o,
    output logic       grp_start_o
);

    localparam int CNT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             ctr_q;
    logic             start_q;
    logic             hz_raw;
    logic             fire;
    logic             is_br;

    assign is_br = (unit_e'(unit_i) == UNIT_BR);
    assign fire  = in_valid_i && in_accept_i && !pseudo_i;

    dgrp_rules #(
        .NUM_SLOTS  (NUM_SLOTS),
        .CR_LIMIT   (CR_LIMIT),
        .CRACK_SLOTS(CRACK_SLOTS),
        .CNT_W      (CNT_W)
    ) u_rules (
        .unit_i      (unit_i),
        .first_only_i(first_only_i),
        .single_i    (single_i),
        .cracked_i   (cracked_i),
        .pseudo_i    (pseudo_i),
        .uses_ctr_i  (uses_ctr_i),
        .cnt_i       (cnt_q),
        .ctr_set_i   (ctr_q),
        .hazard_o    (hz_raw)
    );

    dgrp_state #(
        .CRACK_SLOTS(CRACK_SLOTS),
        .CNT_W      (CNT_W)
    ) u_state (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (fire),
        .hazard_i  (hz_raw),
        .is_br_i   (is_br),
        .single_i  (single_i),
        .cracked_i (cracked_i),
        .sets_ctr_i(sets_ctr_i),
        .cnt_q     (cnt_q),
        .ctr_set_q (ctr_q),
        .start_q   (start_q)
    );

    assign hazard_o    = in_valid_i && hz_raw;
    assign grp_start_o = start_q;

endmodule

// File: rtl/dgrp_slot_gate_chk.sv
module dgrp_slot_gate_chk #(
    parameter int NUM_SLOTS   = 5,
    parameter int CR_LIMIT    = 2,
    parameter int CRACK_SLOTS = 2,
    parameter int CNT_W       = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             in_valid_i,
    input logic             in_accept_i,
    input logic [2:0]       unit_i,
    input logic             single_i,
    input logic             cracked_i,
    input logic             pseudo_i,
    input logic             uses_ctr_i,
    input logic             hazard_o,
    input logic             grp_start_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ctr_q
);

    localparam logic [2:0] BR_CODE = 3'd6;
    localparam logic [2:0] CR_CODE = 3'd5;
    localparam int         LAST    = NUM_SLOTS - 1;

    logic hs;
    logic admit;
    assign hs    = in_valid_i && in_accept_i;
    assign admit = hs && !pseudo_i && !hazard_o;

    a_r11_quiet_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |-> !hazard_o);

    a_r11_hold_without_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hs |=> ($stable(cnt_q) && $stable(ctr_q) && !grp_start_o));

    a_r7_pseudo_no_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && pseudo_i) |-> !hazard_o);

    a_r7_pseudo_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs && pseudo_i) |=> ($stable(cnt_q) && $stable(ctr_q) && !grp_start_o));

    // R8 and R9 both lead to the clearing checked for R10
    a_r10_close_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs && !pseudo_i && (hazard_o || unit_i == BR_CODE || single_i))
        |=> (grp_start_o && cnt_q == '0 && !ctr_q));

    a_r10_pulse_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grp_start_o |-> (cnt_q == '0 && !ctr_q));

    a_r4_last_slot_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (admit && cnt_q == CNT_W'(LAST)) |-> (unit_i == BR_CODE));

    a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(LAST));

    a_r3_cracked_takes_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (admit && cracked_i && unit_i != BR_CODE && !single_i)
        |=> (cnt_q == $past(cnt_q) + CNT_W'(CRACK_SLOTS)));

    a_r5_cr_leading_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (admit && unit_i == CR_CODE) |-> (cnt_q < CNT_W'(CR_LIMIT)));

    a_r6_ctr_write_then_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !pseudo_i && uses_ctr_i && ctr_q) |-> hazard_o);

    a_r2_leader_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (admit && single_i) |-> (cnt_q == '0));

endmodule

bind dgrp_slot_gate dgrp_slot_gate_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .CR_LIMIT   (CR_LIMIT),
    .CRACK_SLOTS(CRACK_SLOTS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_accept_i(in_accept_i),
    .unit_i     (unit_i),
    .single_i   (single_i),
    .cracked_i  (cracked_i),
    .pseudo_i   (pseudo_i),
    .uses_ctr_i (uses_ctr_i),
    .hazard_o   (hazard_o),
    .grp_start_o(grp_start_o),
    .cnt_q      (cnt_q),
    .ctr_q      (ctr_q)
);

// File: tb/dgrp_slot_gate_tb.sv
module dgrp_slot_gate_tb;

    localparam logic [2:0] U_FIX   = 3'd0;
    localparam logic [2:0] U_LDST  = 3'd1;
    localparam logic [2:0] U_FLT   = 3'd2;
    localparam logic [2:0] U_VALU  = 3'd3;
    localparam logic [2:0] U_VPERM = 3'd4;
    localparam logic [2:0] U_CR    = 3'd5;
    localparam logic [2:0] U_BR    = 3'd6;
    localparam logic [2:0] U_SPARE = 3'd7;

    // flag vector {first_only, single, cracked, pseudo, sets_ctr, uses_ctr}
    localparam logic [5:0] F_NONE  = 6'b000000;
    localparam logic [5:0] F_FIRST = 6'b100000;
    localparam logic [5:0] F_SING  = 6'b010000;
    localparam logic [5:0] F_CRACK = 6'b001000;
    localparam logic [5:0] F_PSEU  = 6'b000100;
    localparam logic [5:0] F_MT    = 6'b000010;
    localparam logic [5:0] F_BC    = 6'b000001;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid;
    logic       accept;
    logic [2:0] unit;
    logic [5:0] flags;
    logic       hazard;
    logic       gstart;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dgrp_slot_gate u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (valid),
        .in_accept_i (accept),
        .unit_i      (unit),
        .first_only_i(flags[5]),
        .single_i    (flags[4]),
        .cracked_i   (flags[3]),
        .pseudo_i    (flags[2]),
        .sets_ctr_i  (flags[1]),
        .uses_ctr_i  (flags[0]),
        .hazard_o    (hazard),
        .grp_start_o (gstart)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Starts at a falling edge; offers one descriptor for one cycle.
    task automatic offer(input logic [2:0] u, input logic [5:0] f, input logic acc,
                         input logic exp_hz, input logic exp_gs, input string tag);
        valid  = 1'b1;
        accept = acc;
        unit   = u;
        flags  = f;
        #1;
        check(hazard, exp_hz, {tag, " hazard"});
        @(posedge clk);
        @(negedge clk);
        valid  = 1'b0;
        accept = 1'b0;
        flags  = F_NONE;
        check(gstart, exp_gs, {tag, " group start"});
    endtask

    task automatic t_reset_state();
        check(gstart, 1'b0, "R1 start low after reset");
        check(hazard, 1'b0, "R1 hazard low when idle");
        offer(U_FIX, F_FIRST, 1'b1, 1'b0, 1'b0, "R1 first-only in empty group");
        offer(U_BR,  F_NONE,  1'b1, 1'b0, 1'b1, "R8 branch closes");
    endtask

    task automatic t_fill_and_branch();
        offer(U_FIX,  F_NONE, 1'b1, 1'b0, 1'b0, "R4 slot1");
        offer(U_LDST, F_NONE, 1'b1, 1'b0, 1'b0, "R4 slot2");
        offer(U_FLT,  F_NONE, 1'b1, 1'b0, 1'b0, "R4 slot3");
        offer(U_VALU, F_NONE, 1'b1, 1'b0, 1'b0, "R4 slot4");
        offer(U_FIX,  F_NONE, 1'b1, 1'b1, 1'b1, "R9 non-branch in last slot refused");
        offer(U_FIX,  F_SING, 1'b1, 1'b0, 1'b1, "R10 cleared then R8 single closes");
        for (int i = 0; i < 4; i++)
            offer(U_FIX, F_NONE, 1'b1, 1'b0, 1'b0, "R4 refill");
        offer(U_BR, F_NONE, 1'b1, 1'b0, 1'b1, "R4 branch in fifth slot");
        offer(U_BR, F_NONE, 1'b1, 1'b0, 1'b1, "R8 lone branch closes");
    endtask

    task automatic t_first_and_cr();
        offer(U_CR,  F_NONE,  1'b1, 1'b0, 1'b0, "R5 CR in slot1");
        offer(U_FIX, F_FIRST, 1'b0, 1'b1, 1'b0, "R2 first-only after one slot");
        offer(U_FIX, F_SING,  1'b0, 1'b1, 1'b0, "R2 single after one slot");
        // R11: descriptor that would be refused, but valid low
        valid = 1'b0; unit = U_FIX; flags = F_FIRST;
        #1;
        check(hazard, 1'b0, "R11 no hazard without valid");
        @(posedge clk);
        @(negedge clk);
        flags = F_NONE;
        check(gstart, 1'b0, "R11 no close without handshake");
        offer(U_CR, F_NONE, 1'b1, 1'b0, 1'b0, "R5 CR in slot2");
        offer(U_CR, F_NONE, 1'b1, 1'b1, 1'b1, "R5 CR refused at two, R9 closes");
    endtask

    task automatic t_cracked();
        offer(U_FIX,  F_CRACK, 1'b1, 1'b0, 1'b0, "R3 cracked at zero");
        offer(U_LDST, F_CRACK, 1'b1, 1'b0, 1'b0, "R3 cracked at two");
        offer(U_FIX,  F_NONE,  1'b0, 1'b1, 1'b0, "R3 two cracked fill four slots");
        offer(U_BR,   F_NONE,  1'b1, 1'b0, 1'b1, "R3 branch after cracked pair");
        for (int i = 0; i < 3; i++)
            offer(U_FIX, F_NONE, 1'b1, 1'b0, 1'b0, "R3 fill to three");
        offer(U_FLT, F_CRACK, 1'b0, 1'b1, 1'b0, "R3 cracked refused at three");
        offer(U_BR,  F_NONE,  1'b1, 1'b0, 1'b1, "R3 close");
    endtask

    task automatic t_count_reg();
        offer(U_BR,  F_BC,   1'b1, 1'b0, 1'b1, "R6 bctr with no prior write");
        offer(U_FIX, F_MT,   1'b1, 1'b0, 1'b0, "R6 count-register write");
        offer(U_FIX, F_NONE, 1'b1, 1'b0, 1'b0, "R6 filler");
        offer(U_BR,  F_BC,   1'b1, 1'b1, 1'b1, "R6 bctr after write refused");
        offer(U_BR,  F_BC,   1'b1, 1'b0, 1'b1, "R10 record cleared in new group");
    endtask

    task automatic t_pseudo();
        for (int i = 0; i < 3; i++)
            offer(U_FIX, F_NONE, 1'b1, 1'b0, 1'b0, "R7 fill to three");
        offer(U_FIX, F_PSEU | F_FIRST, 1'b1, 1'b0, 1'b0, "R7 pseudo first-only");
        offer(U_BR,  F_PSEU,           1'b1, 1'b0, 1'b0, "R7 pseudo branch no close");
        offer(U_FLT, F_PSEU | F_CRACK, 1'b1, 1'b0, 1'b0, "R7 pseudo cracked");
        offer(U_FIX, F_NONE,           1'b1, 1'b0, 1'b0, "R7 count still three");
        offer(U_FIX, F_NONE,           1'b0, 1'b1, 1'b0, "R7 count now four");
        offer(U_BR,  F_NONE,           1'b1, 1'b0, 1'b1, "R7 close");
        offer(U_FIX, F_PSEU | F_MT,    1'b1, 1'b0, 1'b0, "R7 pseudo count write");
        offer(U_BR,  F_BC,             1'b1, 1'b0, 1'b1, "R7 pseudo write not recorded");
    endtask

    task automatic t_classes();
        for (int i = 0; i < 4; i++)
            offer(U_LDST, F_NONE, 1'b1, 1'b0, 1'b0, "R4 fill");
        offer(U_VPERM, F_NONE, 1'b0, 1'b1, 1'b0, "R4 vector permute in last slot");
        offer(U_SPARE, F_NONE, 1'b0, 1'b1, 1'b0, "R4 spare code in last slot");
        offer(U_CR,    F_NONE, 1'b0, 1'b1, 1'b0, "R5 CR in last slot");
        offer(U_BR,    F_NONE, 1'b1, 1'b0, 1'b1, "R4 branch takes last slot");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        valid  = 1'b0;
        accept = 1'b0;
        unit   = U_FIX;
        flags  = F_NONE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        t_reset_state();
        t_fill_and_branch();
        t_first_and_cr();
        t_cracked();
        t_count_reg();
        t_pseudo();
        t_classes();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule